// File: doc/BRIEF.md
# Interrupt Line Distributor

The distributor watches a bank of interrupt request lines and turns each new request into a single delivery message aimed at one of several processor cores. Every line has its own configuration entry: a mask bit, a priority, a destination mode and a destination value. In physical mode the destination value names a core directly. In logical mode it names a group, and the request goes to whichever member of that group is currently least busy, as shown by the task-priority value each core reports.

A request is seen on the rising edge of its line and is held pending until it is issued. At most one message leaves per clock. When several lines wait at once, the lowest-numbered one goes first. A request whose destination names no existing core is discarded, and a sticky error flag is raised.

Software or a controller loads the per-line entries through a one-cycle write port. The cores drive their group IDs and task-priority values onto the block continuously.

Top module: `irq_line_distributor`

## Requirements
- R1: After reset `dlv_valid` and `err_nodest` are 0, and every line's mask bit is 1 (masked), so no edge produces a delivery until the line is configured.
- R2: A 0-to-1 change on an unmasked `irq_in` line, sampled at clock edge k, gives exactly one delivery with `dlv_valid` high in the cycle after edge k+1 when no lower line is pending. A line held high gives no further delivery.
- R3: A masked line produces no delivery. A request that is already pending is discarded from the first edge at which its line's mask bit reads 1.
- R4: A delivery carries the configured priority of its line on `dlv_prio` and the line index on `dlv_line`.
- R5: In physical mode (`cfg_logical`=0) `dlv_core` equals the configured destination value, which must be below NUM_CORES.
- R6: In logical mode (`cfg_logical`=1) the delivery targets the core whose group ID (field c of `core_group`, bits [c*GROUP_W +: GROUP_W]) equals the destination and whose task priority (field c of `core_tpr`) is lowest. The values are sampled at the edge where the request is issued.
- R7: When group members tie on the lowest task priority, the lowest core index wins.
- R8: At most one delivery is made per cycle, and among pending unmasked lines the lowest-numbered one is issued first. The others stay pending.
- R9: A logical destination that matches no core, or a physical destination of NUM_CORES or more, consumes the request with no delivery and sets `err_nodest`. The flag stays set until reset.
- R10: A pulse of `cfg_we` writes the mask, priority, mode and destination of line `cfg_line`, effective from the next edge. A write to a line index of NUM_LINES or more changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Interrupt request lines, bit i is line i |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_line | input | LINE_W | Line index being written |
| cfg_mask | input | 1 | Mask bit to write (1 = masked) |
| cfg_prio | input | PRIO_W | Priority to write |
| cfg_logical | input | 1 | Destination mode to write (0 physical, 1 logical) |
| cfg_dest | input | DEST_W | Core index or group ID to write |
| core_group | input | NUM_CORES*GROUP_W | Group ID of each core, field c for core c |
| core_tpr | input | NUM_CORES*PRIO_W | Task-priority value of each core, field c for core c |
| dlv_valid | output | 1 | Delivery message valid for this cycle |
| dlv_core | output | CORE_W | Target core of the delivery |
| dlv_prio | output | PRIO_W | Priority of the delivered line |
| dlv_line | output | LINE_W | Index of the delivered line |
| err_nodest | output | 1 | Sticky flag: a request had no reachable core |

## Verification
The bench runs single pulses and held-high lines to separate edge detection from level sensing. It raises several lines in the same cycle to expose the issue order and to show whether the block emits one message per cycle. For logical routing, the core task priorities are shuffled between requests so that a stale or highest-value choice is caught, and equal values show whether ties go to the lower core index. Unknown groups, out-of-range core indices, masking of an already pending line and writes to a non-existent line test the drop, sticky-flag and ignore paths.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   typedef enum logic {
      DEST_PHYS    = 1'b0,
      DEST_LOGICAL = 1'b1
   } dest_mode_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/irqd_cfg_table.sv
module irqd_cfg_table
   import irqd_pkg::*;
#(
   parameter int NUM_LINES = 24,
   parameter int PRIO_W    = 4,
   parameter int DEST_W    = 4,
   parameter int LINE_W    = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [LINE_W-1:0]           wr_line,
   input  logic                        wr_mask,
   input  logic [PRIO_W-1:0]           wr_prio,
   input  logic                        wr_logical,
   input  logic [DEST_W-1:0]           wr_dest,
   output logic [NUM_LINES-1:0]        mask_vec,
   output logic [NUM_LINES*PRIO_W-1:0] prio_flat,
   output logic [NUM_LINES-1:0]        logical_vec,
   output logic [NUM_LINES*DEST_W-1:0] dest_flat
);
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_entry
      logic       hit;
      dest_mode_e mode_q;
      assign hit = wr_en && (wr_line == LINE_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_vec[i]                   <= 1'b1;
            prio_flat[i*PRIO_W +: PRIO_W] <= '0;
            mode_q                        <= DEST_PHYS;
            dest_flat[i*DEST_W +: DEST_W] <= '0;
         end else if (hit) begin
            mask_vec[i]                   <= wr_mask;
            prio_flat[i*PRIO_W +: PRIO_W] <= wr_prio;
            mode_q                        <= wr_logical ? DEST_LOGICAL : DEST_PHYS;
            dest_flat[i*DEST_W +: DEST_W] <= wr_dest;
         end
      end
      assign logical_vec[i] = (mode_q == DEST_LOGICAL);
   end
endmodule

// File: rtl/irqd_detect.sv
module irqd_detect #(
   parameter int NUM_LINES = 24,
   parameter int LINE_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic [NUM_LINES-1:0] mask_vec,
   output logic                 sel_valid,
   output logic [LINE_W-1:0]    sel_line
);
   logic [NUM_LINES-1:0] irq_q;
   logic [NUM_LINES-1:0] pend_q;
   logic [NUM_LINES-1:0] edge_vec;
   logic [NUM_LINES-1:0] eligible;
   logic [NUM_LINES-1:0] issue_vec;

   assign edge_vec = irq_in & ~irq_q;
   assign eligible = pend_q & ~mask_vec;

   always_comb begin
      sel_valid = 1'b0;
      sel_line  = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (eligible[i]) begin
            sel_valid = 1'b1;
            sel_line  = LINE_W'(i);
         end
      end
      issue_vec = sel_valid ? (NUM_LINES'(1) << sel_line) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q  <= '0;
         pend_q <= '0;
      end else begin
         irq_q  <= irq_in;
         pend_q <= (eligible & ~issue_vec) | (edge_vec & ~mask_vec);
      end
   end

   // issued request leaves the pending set unless a fresh edge re-arms it
   assert_issue_clears_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(issue_vec & ~edge_vec)) == '0));

   // nothing below the chosen line may be eligible
   assert_lowest_first_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> ((eligible & (issue_vec - NUM_LINES'(1))) == '0));

   assert_one_issue_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(issue_vec));
endmodule

// File: rtl/irqd_route.sv
module irqd_route #(
   parameter int NUM_CORES = 4,
   parameter int PRIO_W    = 4,
   parameter int GROUP_W   = 4,
   parameter int DEST_W    = 4,
   parameter int CORE_W    = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic                          req_logical,
   input  logic [DEST_W-1:0]             req_dest,
   input  logic [NUM_CORES*GROUP_W-1:0]  core_group,
   input  logic [NUM_CORES*PRIO_W-1:0]   core_tpr,
   output logic                          hit,
   output logic [CORE_W-1:0]             core_idx
);
   logic [PRIO_W-1:0]    tpr_a [NUM_CORES];
   logic [NUM_CORES-1:0] member;
   logic [31:0]          dest_wide;
   logic                 phys_ok;
   logic                 grp_found;
   logic [CORE_W-1:0]    grp_idx;
   logic [PRIO_W-1:0]    grp_tpr;

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assign tpr_a[c]  = core_tpr[c*PRIO_W +: PRIO_W];
      assign member[c] = (core_group[c*GROUP_W +: GROUP_W] == req_dest[GROUP_W-1:0]);
   end

   if (DEST_W > GROUP_W) begin : g_wide_dest
      logic upper_zero;
      assign upper_zero = (req_dest[DEST_W-1:GROUP_W] == '0);
      logic [NUM_CORES-1:0] member_q;
      assign member_q = upper_zero ? member : '0;
      always_comb begin
         grp_found = 1'b0;
         grp_idx   = '0;
         grp_tpr   = '1;
         for (int c = 0; c < NUM_CORES; c++) begin
            if (member_q[c] && (!grp_found || (tpr_a[c] < grp_tpr))) begin
               grp_found = 1'b1;
               grp_idx   = CORE_W'(c);
               grp_tpr   = tpr_a[c];
            end
         end
      end
   end else begin : g_exact_dest
      always_comb begin
         grp_found = 1'b0;
         grp_idx   = '0;
         grp_tpr   = '1;
         for (int c = 0; c < NUM_CORES; c++) begin
            if (member[c] && (!grp_found || (tpr_a[c] < grp_tpr))) begin
               grp_found = 1'b1;
               grp_idx   = CORE_W'(c);
               grp_tpr   = tpr_a[c];
            end
         end
      end
   end

   assign dest_wide = 32'(req_dest);
   assign phys_ok   = (dest_wide < 32'(NUM_CORES));

   always_comb begin
      if (req_logical) begin
         hit      = grp_found;
         core_idx = grp_idx;
      end else begin
         hit      = phys_ok;
         core_idx = req_dest[CORE_W-1:0];
      end
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
      // the winner is never busier than any member
      assert_lowest_tpr_R6 : assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_logical && hit && member[c] && (DEST_W == GROUP_W))
            |-> (tpr_a[core_idx] <= tpr_a[c]));
      // equal load resolves to the smaller core index
      assert_tie_low_index_R7 : assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_logical && hit && member[c] && (DEST_W == GROUP_W)
            && (tpr_a[c] == tpr_a[core_idx])) |-> (32'(core_idx) <= 32'(c)));
   end
endmodule

// File: rtl/irq_line_distributor.sv
module irq_line_distributor
   import irqd_pkg::*;
#(
   parameter int NUM_LINES = 24,
   parameter int NUM_CORES = 4,
   parameter int PRIO_W    = 4,
   parameter int GROUP_W   = 4,
   localparam int LINE_W   = idx_width(NUM_LINES),
   localparam int CORE_W   = idx_width(NUM_CORES),
   localparam int DEST_W   = (GROUP_W > CORE_W) ? GROUP_W : CORE_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_LINES-1:0]         irq_in,
   input  logic                         cfg_we,
   input  logic [LINE_W-1:0]            cfg_line,
   input  logic                         cfg_mask,
   input  logic [PRIO_W-1:0]            cfg_prio,
   input  logic                         cfg_logical,
   input  logic [DEST_W-1:0]            cfg_dest,
   input  logic [NUM_CORES*GROUP_W-1:0] core_group,
   input  logic [NUM_CORES*PRIO_W-1:0]  core_tpr,
   output logic                         dlv_valid,
   output logic [CORE_W-1:0]            dlv_core,
   output logic [PRIO_W-1:0]            dlv_prio,
   output logic [LINE_W-1:0]            dlv_line,
   output logic                         err_nodest
);
   if (NUM_LINES < 1 || NUM_CORES < 1 || PRIO_W < 1 || GROUP_W < 1) begin : g_bad_param
      $error("irq_line_distributor: every size parameter must be at least 1");
   end

   logic [NUM_LINES-1:0]        mask_vec;
   logic [NUM_LINES*PRIO_W-1:0] prio_flat;
   logic [NUM_LINES-1:0]        logical_vec;
   logic [NUM_LINES*DEST_W-1:0] dest_flat;
   logic                        sel_valid;
   logic [LINE_W-1:0]           sel_line;
   logic [PRIO_W-1:0]           sel_prio;
   logic                        sel_logical;
   logic [DEST_W-1:0]           sel_dest;
   logic                        route_hit;
   logic [CORE_W-1:0]           route_core;

   irqd_cfg_table #(
      .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .DEST_W(DEST_W), .LINE_W(LINE_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_line(cfg_line), .wr_mask(cfg_mask), .wr_prio(cfg_prio),
      .wr_logical(cfg_logical), .wr_dest(cfg_dest),
      .mask_vec(mask_vec), .prio_flat(prio_flat),
      .logical_vec(logical_vec), .dest_flat(dest_flat)
   );

   irqd_detect #(
      .NUM_LINES(NUM_LINES), .LINE_W(LINE_W)
   ) u_detect (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_vec(mask_vec),
      .sel_valid(sel_valid), .sel_line(sel_line)
   );

   always_comb begin
      sel_prio    = '0;
      sel_logical = 1'b0;
      sel_dest    = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (sel_line == LINE_W'(i)) begin
            sel_prio    = prio_flat[i*PRIO_W +: PRIO_W];
            sel_logical = logical_vec[i];
            sel_dest    = dest_flat[i*DEST_W +: DEST_W];
         end
      end
   end

   irqd_route #(
      .NUM_CORES(NUM_CORES), .PRIO_W(PRIO_W), .GROUP_W(GROUP_W),
      .DEST_W(DEST_W), .CORE_W(CORE_W)
   ) u_route (
      .clk(clk), .rst_n(rst_n),
      .req_valid(sel_valid), .req_logical(sel_logical), .req_dest(sel_dest),
      .core_group(core_group), .core_tpr(core_tpr),
      .hit(route_hit), .core_idx(route_core)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dlv_valid  <= 1'b0;
         dlv_core   <= '0;
         dlv_prio   <= '0;
         dlv_line   <= '0;
         err_nodest <= 1'b0;
      end else begin
         dlv_valid  <= sel_valid && route_hit;
         dlv_core   <= route_core;
         dlv_prio   <= sel_prio;
         dlv_line   <= sel_line;
         err_nodest <= err_nodest || (sel_valid && !route_hit);
      end
   end

   assert_err_sticky_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      err_nodest |=> err_nodest);

   assert_core_range_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> (32'(dlv_core) < 32'(NUM_CORES)));

   assert_no_masked_dlv_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> ((($past(mask_vec)) >> dlv_line) & NUM_LINES'(1)) == '0);

   assert_dlv_in_range_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> (32'(dlv_line) < 32'(NUM_LINES)));
endmodule

// File: tb/irq_line_distributor_bench.sv
module irq_line_distributor_bench;
   localparam int NL = 24;
   localparam int NC = 4;
   localparam int PW = 4;
   localparam int GW = 4;
   localparam int LW = 5;
   localparam int CW = 2;
   localparam int DW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] irq_in = '0;
   logic          cfg_we = 1'b0;
   logic [LW-1:0] cfg_line = '0;
   logic          cfg_mask = 1'b0;
   logic [PW-1:0] cfg_prio = '0;
   logic          cfg_logical = 1'b0;
   logic [DW-1:0] cfg_dest = '0;
   logic [NC*GW-1:0] core_group = '0;
   logic [NC*PW-1:0] core_tpr = '0;
   logic          dlv_valid;
   logic [CW-1:0] dlv_core;
   logic [PW-1:0] dlv_prio;
   logic [LW-1:0] dlv_line;
   logic          err_nodest;

   always #4 clk = ~clk;

   irq_line_distributor #(.NUM_LINES(NL), .NUM_CORES(NC), .PRIO_W(PW), .GROUP_W(GW))
   u_irq_line_distributor (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_line(cfg_line),
      .cfg_mask(cfg_mask), .cfg_prio(cfg_prio), .cfg_logical(cfg_logical),
      .cfg_dest(cfg_dest), .core_group(core_group), .core_tpr(core_tpr),
      .dlv_valid(dlv_valid), .dlv_core(dlv_core), .dlv_prio(dlv_prio),
      .dlv_line(dlv_line), .err_nodest(err_nodest)
   );

   int    n_checks = 0;
   int    n_fails = 0;
   string phase = "R1 reset";
   int    dlv_seen = 0;

   // reference model state
   bit m_mask [NL];
   int m_prio [NL];
   bit m_log  [NL];
   int m_dest [NL];
   bit m_pend [NL];
   bit m_prev [NL];
   bit live = 0;
   bit exp_valid = 0;
   int exp_core = 0, exp_prio = 0, exp_line = 0;
   bit exp_err = 0;

   task automatic check(input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s actual %0d expected %0d", phase, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NL; i++) begin
            m_mask[i] = 1; m_prio[i] = 0; m_log[i] = 0; m_dest[i] = 0;
            m_pend[i] = 0; m_prev[i] = 0;
         end
         exp_valid = 0; exp_err = 0; live = 0;
      end else begin
         int pick;
         live = 1;
         pick = -1;
         for (int i = 0; i < NL; i++)
            if (pick < 0 && m_pend[i] && !m_mask[i]) pick = i;
         exp_valid = 0;
         if (pick >= 0) begin
            int best;
            best = -1;
            if (m_log[pick]) begin
               for (int c = 0; c < NC; c++)
                  if (int'(core_group[c*GW +: GW]) == m_dest[pick] &&
                      (best < 0 || int'(core_tpr[c*PW +: PW]) < int'(core_tpr[best*PW +: PW])))
                     best = c;
            end else if (m_dest[pick] < NC) begin
               best = m_dest[pick];
            end
            if (best >= 0) begin
               exp_valid = 1; exp_core = best; exp_prio = m_prio[pick]; exp_line = pick;
            end else begin
               exp_err = 1;
            end
            m_pend[pick] = 0;
         end
         for (int i = 0; i < NL; i++) begin
            m_pend[i] = (m_pend[i] && !m_mask[i]) || (irq_in[i] && !m_prev[i] && !m_mask[i]);
            m_prev[i] = irq_in[i];
         end
         if (cfg_we && int'(cfg_line) < NL) begin
            m_mask[cfg_line] = cfg_mask; m_prio[cfg_line] = int'(cfg_prio);
            m_log[cfg_line] = cfg_logical; m_dest[cfg_line] = int'(cfg_dest);
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && live) begin
         check("dlv_valid", int'(dlv_valid), int'(exp_valid));
         if (exp_valid && dlv_valid) begin
            check("dlv_core", int'(dlv_core), exp_core);
            check("dlv_prio", int'(dlv_prio), exp_prio);
            check("dlv_line", int'(dlv_line), exp_line);
         end
         check("err_nodest", int'(err_nodest), int'(exp_err));
         if (dlv_valid) dlv_seen++;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_line(input int line, input bit msk, input int prio,
                             input bit lg, input int dest);
      @(negedge clk);
      cfg_we = 1; cfg_line = LW'(line); cfg_mask = msk; cfg_prio = PW'(prio);
      cfg_logical = lg; cfg_dest = DW'(dest);
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic set_cores(input int g0, input int g1, input int g2, input int g3,
                            input int t0, input int t1, input int t2, input int t3);
      core_group = {GW'(g3), GW'(g2), GW'(g1), GW'(g0)};
      core_tpr   = {PW'(t3), PW'(t2), PW'(t1), PW'(t0)};
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_fails++;
      $display("FAIL %s watchdog expired actual 0 expected 1", phase);
      finish_run();
   end

   initial begin
      set_cores(1, 1, 2, 1, 5, 3, 0, 3);
      wait_cyc(3);
      phase = "R1 reset state";
      check("dlv_valid", int'(dlv_valid), 0);
      check("err_nodest", int'(err_nodest), 0);
      rst_n = 1;
      wait_cyc(1);
      // R1: lines come out of reset masked
      irq_in[3] = 1; wait_cyc(2); irq_in[3] = 0; wait_cyc(4);
      check("R1 deliveries from masked line", dlv_seen, 0);

      phase = "R2 R4 R5 physical single";
      write_line(3, 0, 9, 0, 2);
      dlv_seen = 0;
      irq_in[3] = 1; wait_cyc(8);
      check("R2 one delivery for held line", dlv_seen, 1);
      irq_in[3] = 0; wait_cyc(3);

      phase = "R8 simultaneous order";
      write_line(5, 0, 4, 0, 1);
      write_line(2, 0, 7, 0, 3);
      write_line(7, 0, 12, 0, 0);
      dlv_seen = 0;
      irq_in[2] = 1; irq_in[5] = 1; irq_in[7] = 1;
      wait_cyc(1);
      irq_in = '0;
      wait_cyc(6);
      check("R8 deliveries for three lines", dlv_seen, 3);

      phase = "R6 R7 logical lowest and tie";
      write_line(10, 0, 6, 1, 1);
      irq_in[10] = 1; wait_cyc(1); irq_in[10] = 0; wait_cyc(4);
      set_cores(1, 1, 2, 1, 5, 3, 0, 1);
      phase = "R6 logical lowest after change";
      irq_in[10] = 1; wait_cyc(1); irq_in[10] = 0; wait_cyc(4);
      set_cores(2, 1, 2, 1, 0, 8, 7, 8);
      phase = "R7 tie two members";
      irq_in[10] = 1; wait_cyc(1); irq_in[10] = 0; wait_cyc(4);

      phase = "R3 mask pending line";
      write_line(8, 0, 1, 0, 1);
      write_line(9, 0, 2, 0, 2);
      dlv_seen = 0;
      irq_in[8] = 1; irq_in[9] = 1;
      @(negedge clk);
      irq_in[8] = 0; irq_in[9] = 0;
      cfg_we = 1; cfg_line = 9; cfg_mask = 1; cfg_prio = 2; cfg_logical = 0; cfg_dest = 2;
      @(negedge clk);
      cfg_we = 0;
      wait_cyc(5);
      check("R3 only unmasked line delivered", dlv_seen, 1);

      phase = "R10 write to absent line";
      write_line(30, 1, 0, 0, 0);
      dlv_seen = 0;
      irq_in[3] = 1; wait_cyc(1); irq_in[3] = 0; wait_cyc(4);
      check("R10 line 3 still delivers", dlv_seen, 1);

      phase = "R9 logical no match";
      write_line(11, 0, 3, 1, 7);
      irq_in[11] = 1; wait_cyc(1); irq_in[11] = 0; wait_cyc(4);
      check("R9 err set", int'(err_nodest), 1);
      phase = "R9 physical out of range";
      write_line(12, 0, 3, 0, 6);
      irq_in[12] = 1; wait_cyc(1); irq_in[12] = 0; wait_cyc(4);
      phase = "R9 sticky after good delivery";
      irq_in[3] = 1; wait_cyc(1); irq_in[3] = 0; wait_cyc(4);
      check("R9 err still set", int'(err_nodest), 1);

      finish_run();
   end
endmodule